// File: doc/BRIEF.md
# Bidirectional I/O Port with Pull Control

An eight-bit general-purpose I/O port that a processor controls through a small register bus. Three registers set it up: a data latch, a per-bit pull-enable mask and a per-bit direction mask. The pin side has three vectors. The port drives an output value and an output enable, and it samples an input value through a two-flop synchroniser. Two further vectors tell the pad whether to switch on an internal pull-up or pull-down device for each bit.

The upper four bits can also serve as inputs to a keyboard-interrupt block. That block tells the port, through side-band inputs, which of those pins it has taken and which of them sense rising edges or high levels. For such a pin, an active pull enable turns on a pull-down instead of a pull-up. A pull-down holds the idle level away from the level that would raise the interrupt.

Bus access is a single cycle. Writes take effect at the clock edge where the write enable is high. Reads are combinational from the current register contents and the synchronised pins.

Top module: `gpio_port`

## Requirements
- R1: A read at offset 0 returns the latched data bit for each bit whose direction is 1. For each bit whose direction is 0, it returns the pin level. A pin change shows in the readback on the second rising clock edge after it, and not on the first.
- R2: A write at offset 0 latches all eight data bits, whatever their direction. A bit written while it was an input reads back its written value once it is switched to output.
- R3: Offset 2 holds the direction mask, where 1 means output and 0 means input. `pin_oe` equals this mask, and `pin_out` carries the latched data register.
- R4: After reset, all three registers read zero. `pin_oe` is zero, `pin_out` is zero and no pull device is enabled.
- R5: Offset 1 holds the pull-enable mask, where 1 enables the device for that bit and 0 disables it. A pull device is on only when the pull-enable bit is 1 and the direction bit is 0. For an output bit, neither pull vector is set.
- R6: For bit n with n from 4 to 7, an enabled pull is a pull-down when both `kbd_sel[n-4]` and `kbd_rise[n-4]` are 1, and a pull-up otherwise. Bits 0 to 3 only ever use the pull-up.
- R7: A read at offset 3 returns zero. A write to offset 3 changes none of the registers.
- R8: `pull_up_en` and `pull_dn_en` are never 1 for the same bit.
- R9: Reads at offsets 1 and 2 return the last values written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pin levels from pads |
| pin_out | output | 8 | Output values to pads |
| pin_oe | output | 8 | Per-bit output enable |
| pull_up_en | output | 8 | Per-bit pull-up enable |
| pull_dn_en | output | 8 | Per-bit pull-down enable |
| kbd_sel | input | 4 | Upper-nibble pin is a keyboard input |
| kbd_rise | input | 4 | Upper-nibble keyboard pin senses rising edge or high level |

## Verification
The bench reads the data offset with a mix of directions. A design that picks the wrong source per bit would return pin levels for output bits, or stale latches for input bits. One check samples the readback one cycle after a pin change, and another samples it two cycles after. A synchroniser with one stage too few or too many fails one of the two. Pull cases mix directions, pull-enable bits and keyboard settings. These cases catch three faults:
- a pull that stays on for output bits;
- a pull-down that leaks into the lower nibble;
- both devices switched on at once.

Further directed tests latch data while a bit is an input and write to the unmapped offset. These expose a write mask that depends on direction and an address decode that is too loose.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        OFS_DATA = 2'd0,
        OFS_PULL = 2'd1,
        OFS_DIR  = 2'd2,
        OFS_NONE = 2'd3
    } gpio_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] bus_rdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] pull_q,
    output logic [WIDTH-1:0] dir_q
);
    gpio_ofs_e ofs;
    logic [WIDTH-1:0] data_view;

    assign ofs = gpio_ofs_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pull_q <= '0;
            dir_q  <= '0;
        end else if (bus_we) begin
            unique case (ofs)
                OFS_DATA: data_q <= bus_wdata;
                OFS_PULL: pull_q <= bus_wdata;
                OFS_DIR:  dir_q  <= bus_wdata;
                OFS_NONE: ;
            endcase
        end
    end

    assign data_view = (data_q & dir_q) | (pin_sync & ~dir_q);

    always_comb begin
        unique case (ofs)
            OFS_DATA: bus_rdata = data_view;
            OFS_PULL: bus_rdata = pull_q;
            OFS_DIR:  bus_rdata = dir_q;
            OFS_NONE: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pull.sv
module gpio_pull #(
    parameter int WIDTH   = 8,
    parameter int KBI_LSB = 4
) (
    input  logic [WIDTH-1:0]         pull_q,
    input  logic [WIDTH-1:0]         dir_q,
    input  logic [WIDTH-KBI_LSB-1:0] kbd_sel,
    input  logic [WIDTH-KBI_LSB-1:0] kbd_rise,
    output logic [WIDTH-1:0]         pull_up_en,
    output logic [WIDTH-1:0]         pull_dn_en
);
    logic [WIDTH-1:0] active;
    logic [WIDTH-1:0] flip;

    assign active = pull_q & ~dir_q;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            if (i >= KBI_LSB) begin : g_kbd
                assign flip[i] = kbd_sel[i-KBI_LSB] & kbd_rise[i-KBI_LSB];
            end else begin : g_plain
                assign flip[i] = 1'b0;
            end
        end
    endgenerate

    assign pull_dn_en = active & flip;
    assign pull_up_en = active & ~flip;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int WIDTH   = 8,
    parameter int KBI_LSB = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               bus_addr,
    input  logic                     bus_we,
    input  logic [WIDTH-1:0]         bus_wdata,
    output logic [WIDTH-1:0]         bus_rdata,
    input  logic [WIDTH-1:0]         pin_in,
    output logic [WIDTH-1:0]         pin_out,
    output logic [WIDTH-1:0]         pin_oe,
    output logic [WIDTH-1:0]         pull_up_en,
    output logic [WIDTH-1:0]         pull_dn_en,
    input  logic [WIDTH-KBI_LSB-1:0] kbd_sel,
    input  logic [WIDTH-KBI_LSB-1:0] kbd_rise
);
    localparam int SYNC_STAGES = 2;

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] pull_q;
    logic [WIDTH-1:0] dir_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .data_q    (data_q),
        .pull_q    (pull_q),
        .dir_q     (dir_q)
    );

    gpio_pull #(.WIDTH(WIDTH), .KBI_LSB(KBI_LSB)) u_pull (
        .pull_q     (pull_q),
        .dir_q      (dir_q),
        .kbd_sel    (kbd_sel),
        .kbd_rise   (kbd_rise),
        .pull_up_en (pull_up_en),
        .pull_dn_en (pull_dn_en)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int WIDTH   = 8,
    parameter int KBI_LSB = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               bus_addr,
    input logic                     bus_we,
    input logic [WIDTH-1:0]         bus_wdata,
    input logic [WIDTH-1:0]         bus_rdata,
    input logic [WIDTH-1:0]         pin_out,
    input logic [WIDTH-1:0]         pin_oe,
    input logic [WIDTH-1:0]         pull_up_en,
    input logic [WIDTH-1:0]         pull_dn_en,
    input logic [WIDTH-KBI_LSB-1:0] kbd_sel,
    input logic [WIDTH-KBI_LSB-1:0] kbd_rise
);
    a_r2_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0) |=> pin_out == $past(bus_wdata));

    a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd2) |=> pin_oe == $past(bus_wdata));

    a_r1_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> ((bus_rdata & pin_oe) == (pin_out & pin_oe)));

    a_r5_no_pull_on_out: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_up_en | pull_dn_en) & pin_oe) == '0);

    a_r6_dn_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_dn_en & ~({kbd_sel & kbd_rise, {KBI_LSB{1'b0}}})) == '0);

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> bus_rdata == '0);

    a_r7_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3) |=> ($stable(pin_out) && $stable(pin_oe)));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up_en & pull_dn_en) == '0);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .KBI_LSB(KBI_LSB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en),
    .kbd_sel    (kbd_sel),
    .kbd_rise   (kbd_rise)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe, pull_up_en, pull_dn_en;
    logic [3:0] kbd_sel = 4'h0;
    logic [3:0] kbd_rise = 4'h0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_up_en(pull_up_en),
        .pull_dn_en(pull_dn_en), .kbd_sel(kbd_sel), .kbd_rise(kbd_rise)
    );

    // {pull_en, dir, kbd_sel, kbd_rise, exp_up, exp_dn}
    localparam logic [39:0] VEC [7] = '{
        {8'hFF, 8'h00, 4'h0, 4'h0, 8'hFF, 8'h00},
        {8'hFF, 8'h0F, 4'hF, 4'hF, 8'h00, 8'hF0},
        {8'hF0, 8'h00, 4'hF, 4'h0, 8'hF0, 8'h00},
        {8'hA5, 8'h81, 4'h5, 4'hF, 8'h24, 8'h00},
        {8'h3C, 8'h00, 4'hA, 4'hA, 8'h1C, 8'h20},
        {8'h00, 8'h00, 4'hF, 4'hF, 8'h00, 8'h00},
        {8'hFF, 8'hFF, 4'hF, 4'hF, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R4 reset state
        check("R4 pin_oe", pin_oe, 8'h00);
        check("R4 pin_out", pin_out, 8'h00);
        check("R4 pulls", pull_up_en | pull_dn_en, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, r); check("R4 data", r, 8'h00);
        rd(2'd1, r); check("R4 pull reg", r, 8'h00);
        rd(2'd2, r); check("R4 dir reg", r, 8'h00);

        // R5 R6 R8 table walk
        for (int i = 0; i < 7; i++) begin
            wr(2'd1, VEC[i][39:32]);
            wr(2'd2, VEC[i][31:24]);
            kbd_sel  = VEC[i][23:20];
            kbd_rise = VEC[i][19:16];
            #1;
            check("R5 R6 pull_up_en", pull_up_en, VEC[i][15:8]);
            check("R6 pull_dn_en", pull_dn_en, VEC[i][7:0]);
            check("R8 exclusive", pull_up_en & pull_dn_en, 8'h00);
            rd(2'd1, r); check("R9 pull readback", r, VEC[i][39:32]);
            rd(2'd2, r); check("R9 dir readback", r, VEC[i][31:24]);
        end

        // R2 latch while input, R3 drive
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h5A);
        check("R3 pin_out", pin_out, 8'h5A);
        check("R3 pin_oe", pin_oe, 8'h00);
        wr(2'd2, 8'hFF);
        rd(2'd0, r); check("R2 latched as input", r, 8'h5A);
        check("R3 pin_oe out", pin_oe, 8'hFF);

        // R1 synchroniser delay and mixed readback
        wr(2'd2, 8'h00);
        bus_addr = 2'd0;
        pin_in = 8'hC3;
        @(negedge clk);
        rd(2'd0, r); check("R1 one cycle", r, 8'h00);
        @(negedge clk);
        rd(2'd0, r); check("R1 two cycles", r, 8'hC3);
        wr(2'd2, 8'hF0);
        rd(2'd0, r); check("R1 mixed", r, 8'h53);

        // R7 unmapped
        wr(2'd1, 8'h3C);
        wr(2'd3, 8'hFF);
        rd(2'd3, r); check("R7 read zero", r, 8'h00);
        rd(2'd1, r); check("R7 pull kept", r, 8'h3C);
        rd(2'd2, r); check("R7 dir kept", r, 8'hF0);
        check("R7 data kept", pin_out, 8'h5A);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule